// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block drives the two-wire management bus that a MAC uses to reach PHY registers. Software sees five 32-bit registers on a simple write-strobe and address register bus. A command word holds the frame type, the opcode, the port and device (or register) address, and a start flag. Writing it with the start flag set sends one complete management frame: a preamble of ones, the start code, the opcode, both address fields, a turnaround and sixteen data bits. Both the short-address frame family (start code 1) and the extended-address family (start code 0) are supported. An extended access takes two commands: an address frame, then a data frame.

Reads release the data line from the turnaround onward. The bits the PHY returns are gathered into the read-data register. A status flag records whether the PHY failed to pull the second turnaround bit low. The management clock is produced only while a frame is in flight. Each half period of it lasts a parameter number of system clocks. Software polls the start flag, which stays 1 until the frame is finished.

Top module: `mdio_master`

## Requirements
- R1: Byte offsets are 0x00 command, 0x04 address, 0x08 write data, 0x0C read data and 0x10 status; after reset every register reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: Command bit 14 is the start flag; a command write with it set starts a frame, and the flag reads back 1 from the next cycle until the last bit of the frame has been sent, then reads 0.
- R3: A command write that arrives while a frame is pending or in progress is dropped: the command fields keep their old value and no extra frame is sent.
- R4: A command write with bit 14 clear stores fields 13:0 (13:12 start code, 11:10 opcode, 9:5 port, 4:0 device/register) without sending a frame, and these read back unchanged.
- R5: Every frame is 64 bits sent MSB first: 32 ones, the 2-bit start code, the 2-bit opcode, the 5-bit port and the 5-bit device/register field.
- R6: A write frame (start code 1 with opcode 1, or start code 0 with opcode 1) sends turnaround 10 and then bits 15:0 of the write-data register; an extended address frame (start code 0, opcode 0) sends turnaround 10 and bits 15:0 of the address register.
- R7: A read frame (start code 1 with opcode 2, or start code 0 with opcode 2 or 3) releases `mdio_oe` for the last 18 bits; the 16 data bits sampled on rising `mdc` go MSB first into read-data bits 15:0.
- R8: Status bit 0 is updated at the end of every read frame: it becomes 1 if the line was high when the second turnaround bit was sampled, else 0.
- R9: `mdc` stays low HALF_DIV clocks and high HALF_DIV clocks per bit. `mdio_o` and `mdio_oe` change only on the edge where `mdc` falls or a frame starts. When no frame is active, `mdc` and `mdio_oe` are 0.
- R10: Writes to the read-data and status offsets have no effect, and read data changes only at the end of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
Every cycle, the assertions check that the management clock and output enable are quiet when the engine is idle, and that the data line holds still while `mdc` is high. They also check that the start flag reads 1 whenever the engine is busy, that a command write during a frame leaves the command fields alone, and that read data holds between frames. Frame content needs the bench's responder scenarios: the preamble and header bits, which of the address or write-data registers is sent, where the line is released, the captured read value and the turnaround error flag. The same holds for the exact MDC half period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int BODY_W  = 32;

    localparam logic [REG_AW-1:0] OFF_CMD  = 5'h00;
    localparam logic [REG_AW-1:0] OFF_ADDR = 5'h04;
    localparam logic [REG_AW-1:0] OFF_WDAT = 5'h08;
    localparam logic [REG_AW-1:0] OFF_RDAT = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_STAT = 5'h10;

    localparam int START_BIT = 14;

    typedef enum logic [1:0] {
        SOF_EXT   = 2'd0,
        SOF_SHORT = 2'd1
    } sof_e;

    localparam logic [1:0] OP_EXT_ADDR  = 2'd0;
    localparam logic [1:0] OP_WRITE     = 2'd1;
    localparam logic [1:0] OP_SHORT_RD  = 2'd2;
    localparam logic [1:0] OP_EXT_RDINC = 2'd2;
    localparam logic [1:0] OP_EXT_RD    = 2'd3;

    localparam logic [1:0] TA_DRIVE = 2'b10;

    typedef struct packed {
        logic [1:0] sof;
        logic [1:0] op;
        logic [4:0] port;
        logic [4:0] dev;
    } mgmt_cmd_t;

    localparam int CMD_W = $bits(mgmt_cmd_t);

    function automatic logic is_read(input mgmt_cmd_t c);
        if (c.sof == SOF_SHORT)
            return c.op == OP_SHORT_RD;
        else
            return (c.op == OP_EXT_RDINC) || (c.op == OP_EXT_RD);
    endfunction

    function automatic logic [BODY_W-1:0] frame_body(input mgmt_cmd_t c,
                                                     input logic [DATA_W-1:0] addr_v,
                                                     input logic [DATA_W-1:0] wr_v);
        logic [DATA_W-1:0] payload;
        payload = ((c.sof == SOF_EXT) && (c.op == OP_EXT_ADDR)) ? addr_v : wr_v;
        return {c.sof, c.op, c.port, c.dev, TA_DRIVE, payload};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          edge_now;

    assign edge_now  = run && (cnt_q == '0);
    assign rise_tick = edge_now && !mdc_q;
    assign fall_tick = edge_now && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= RELOAD;
            mdc_q <= 1'b0;
        end else if (edge_now) begin
            cnt_q <= RELOAD;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] addr_val,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_val,
    output logic              rd_err
);
    localparam int FRAME_BITS = PRE_BITS + BODY_W;
    localparam int IW         = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] TA_IDX   = IW'(PRE_BITS + 14);
    localparam logic [IW-1:0] TA2_IDX  = IW'(PRE_BITS + 15);
    localparam logic [IW-1:0] DATA_IDX = IW'(PRE_BITS + 16);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame_q;
    logic [IW-1:0]         idx_q;
    logic                  busy_q;
    logic                  rd_op_q;
    logic                  ta_bad_q;
    logic [DATA_W-1:0]     shin_q;
    logic                  last_bit;

    assign last_bit = fall_tick && (idx_q == LAST_IDX);
    assign busy     = busy_q;
    assign mdio_o   = frame_q[FRAME_BITS-1];
    assign mdio_oe  = busy_q && !(rd_op_q && (idx_q >= TA_IDX));
    assign rd_done  = last_bit && rd_op_q;
    assign rd_val   = shin_q;
    assign rd_err   = ta_bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q  <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            rd_op_q  <= 1'b0;
            ta_bad_q <= 1'b0;
            shin_q   <= '0;
        end else if (launch && !busy_q) begin
            frame_q  <= {{PRE_BITS{1'b1}}, frame_body(cmd, addr_val, wr_val)};
            idx_q    <= '0;
            busy_q   <= 1'b1;
            rd_op_q  <= is_read(cmd);
            ta_bad_q <= 1'b0;
        end else if (busy_q) begin
            if (rise_tick && rd_op_q) begin
                if (idx_q == TA2_IDX)
                    ta_bad_q <= mdio_i;
                if (idx_q >= DATA_IDX)
                    shin_q <= {shin_q[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
                idx_q   <= idx_q + 1'b1;
                if (last_bit)
                    busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              rd_err,
    output logic              launch,
    output mgmt_cmd_t         cmd,
    output logic [DATA_W-1:0] addr_val,
    output logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] rdat_val,
    output logic              busy_any
);
    mgmt_cmd_t         cmd_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              stat_q;
    logic              launch_q;

    assign busy_any = eng_busy || launch_q;
    assign launch   = launch_q;
    assign cmd      = cmd_q;
    assign addr_val = addr_q;
    assign wr_val   = wdat_q;
    assign rdat_val = rdat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            addr_q   <= '0;
            wdat_q   <= '0;
            rdat_q   <= '0;
            stat_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_CMD: begin
                        if (!busy_any) begin
                            cmd_q    <= mgmt_cmd_t'(reg_wdata[CMD_W-1:0]);
                            launch_q <= reg_wdata[START_BIT];
                        end
                    end
                    OFF_ADDR: addr_q <= reg_wdata[DATA_W-1:0];
                    OFF_WDAT: wdat_q <= reg_wdata[DATA_W-1:0];
                    default: ;
                endcase
            end
            if (rd_done) begin
                rdat_q <= rd_val;
                stat_q <= rd_err;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CMD: begin
                reg_rdata[CMD_W-1:0] = cmd_q;
                reg_rdata[START_BIT] = busy_any;
            end
            OFF_ADDR: reg_rdata[DATA_W-1:0] = addr_q;
            OFF_WDAT: reg_rdata[DATA_W-1:0] = wdat_q;
            OFF_RDAT: reg_rdata[DATA_W-1:0] = rdat_q;
            OFF_STAT: reg_rdata[0]          = stat_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              eng_busy;
    logic              busy_any;
    logic              launch;
    mgmt_cmd_t         cmd;
    logic [DATA_W-1:0] addr_val;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] rdata_word;
    logic              rd_done;
    logic [DATA_W-1:0] rd_val;
    logic              rd_err;
    logic              rise_tick;
    logic              fall_tick;
    logic [CMD_W-1:0]  cmd_word;

    assign cmd_word = cmd;

    mdio_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .eng_busy (eng_busy),
        .rd_done  (rd_done),
        .rd_val   (rd_val),
        .rd_err   (rd_err),
        .launch   (launch),
        .cmd      (cmd),
        .addr_val (addr_val),
        .wr_val   (wr_val),
        .rdat_val (rdata_word),
        .busy_any (busy_any)
    );

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .cmd      (cmd),
        .addr_val (addr_val),
        .wr_val   (wr_val),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .mdio_i   (mdio_i),
        .busy     (eng_busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_val   (rd_val),
        .rd_err   (rd_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              eng_busy,
    input logic              busy_any,
    input logic [CMD_W-1:0]  cmd_word,
    input logic [DATA_W-1:0] rdata_word
);
    AST_START_FLAG_BUSY: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && reg_addr == OFF_CMD) |-> reg_rdata[START_BIT]); // R2

    AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_CMD && busy_any) |=> $stable(cmd_word)); // R3

    AST_LINE_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> (!mdc && !mdio_oe)); // R9

    AST_RDATA_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |=> $stable(rdata_word)); // R10
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .eng_busy  (eng_busy),
    .busy_any  (busy_any),
    .cmd_word  (cmd_word),
    .rdata_word(rdata_word)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int          n_cmp = 0, n_bad = 0;
    bit          finished = 0;
    int          fc = 0, ncap = 0;
    logic [63:0] cap, cap_oe;
    logic        phy_ta = 1'b0;
    logic [15:0] phy_val = '0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF), .PRE_BITS(32)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    function automatic logic phy_drive(input int f, input logic ta, input logic [15:0] v);
        if (f == 47) return ta;
        if (f >= 48 && f <= 63) return v[63 - f];
        return 1'b1;
    endfunction

    assign mdio_i = phy_drive(fc, phy_ta, phy_val);

    always @(negedge mdc) fc = fc + 1;
    always @(posedge mdc) begin
        cap    = {cap[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        ncap   = ncap + 1;
    end

    function automatic logic [63:0] exp_frame(input logic [1:0] st, op,
                                              input logic [4:0] prt, dev,
                                              input logic [15:0] a, w);
        logic [15:0] p;
        p = (st == 2'd0 && op == 2'd0) ? a : w;
        return {32'hFFFF_FFFF, st, op, prt, dev, 2'b10, p};
    endfunction

    function automatic bit is_rd(input logic [1:0] st, op);
        return (st == 2'd1) ? (op == 2'd2) : (op >= 2'd2);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_wr = 1'b0; reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 4000; i++) begin
            rd(5'h00, d);
            if (!d[14]) break;
        end
    endtask

    function automatic logic [31:0] cmd_val(input logic [1:0] st, op, input logic [4:0] prt, dev, input bit go);
        return {17'd0, go, st, op, prt, dev};
    endfunction

    task automatic do_op(input logic [1:0] st, op, input logic [4:0] prt, dev,
                         input logic [15:0] a, w, r, input logic ta_bad);
        logic [31:0] d;
        logic [63:0] e;
        fc = 0; ncap = 0; phy_ta = ta_bad; phy_val = r;
        wr(5'h04, {16'hA5A5, a});
        wr(5'h08, {16'h5A5A, w});
        wr(5'h00, cmd_val(st, op, prt, dev, 1'b1));
        rd(5'h00, d);
        chk(d[14] == 1'b1, "R2 start flag set", d, 64'h4000);
        wait_idle();
        rd(5'h00, d);
        chk(d[14] == 1'b0, "R2 start flag cleared", d, 0);
        e = exp_frame(st, op, prt, dev, a, w);
        chk(ncap == 64, "R5 bit count", ncap, 64);
        chk(cap[63:18] == e[63:18], "R5 header", cap, e);
        if (is_rd(st, op)) begin
            chk(cap_oe == {{46{1'b1}}, 18'd0}, "R7 release", cap_oe, {{46{1'b1}}, 18'd0});
            rd(5'h0C, d);
            chk(d == {16'd0, r}, "R7 read data", d, r);
            rd(5'h10, d);
            chk(d == {31'd0, ta_bad}, "R8 status", d, ta_bad);
        end else begin
            chk(cap_oe == '1, "R6 drive enable", cap_oe, '1);
            chk(cap[17:0] == e[17:0], "R6 turnaround and payload", cap, e);
        end
    endtask

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), d);
            chk(d == 0, "R1 reset register", d, 0);
        end
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset lines", {mdc, mdio_oe}, 0);

        // R4 fields without start flag
        fc = 0; ncap = 0;
        wr(5'h00, cmd_val(2'd1, 2'd2, 5'h13, 5'h0B, 1'b0));
        repeat (20) @(negedge clk);
        rd(5'h00, d);
        chk(d == cmd_val(2'd1, 2'd2, 5'h13, 5'h0B, 1'b0), "R4 fields stored", d,
            cmd_val(2'd1, 2'd2, 5'h13, 5'h0B, 1'b0));
        chk(ncap == 0 && mdio_oe == 1'b0, "R4 no frame", ncap, 0);

        // directed frames
        do_op(2'd1, 2'd1, 5'h1F, 5'h00, 16'h1111, 16'hBEEF, 16'h0, 1'b0);   // R6 short write
        do_op(2'd1, 2'd2, 5'h01, 5'h1F, 16'h0, 16'h0, 16'hC3A5, 1'b0);      // R7 short read
        do_op(2'd0, 2'd0, 5'h0A, 5'h03, 16'h8001, 16'h7777, 16'h0, 1'b0);   // R6 ext address
        do_op(2'd0, 2'd1, 5'h0A, 5'h03, 16'h8001, 16'h1234, 16'h0, 1'b0);   // R6 ext write
        do_op(2'd0, 2'd3, 5'h05, 5'h07, 16'h0, 16'h0, 16'hFFFF, 1'b0);      // R7 ext read
        do_op(2'd0, 2'd2, 5'h05, 5'h07, 16'h0, 16'h0, 16'h0001, 1'b1);      // R8 bad turnaround
        do_op(2'd1, 2'd2, 5'h02, 5'h02, 16'h0, 16'h0, 16'h8000, 1'b0);      // R8 cleared by good read

        // R9 MDC half period
        fc = 0; ncap = 0;
        wr(5'h00, cmd_val(2'd1, 2'd1, 5'h01, 5'h01, 1'b1));
        @(posedge mdc);
        n = 0;
        @(negedge clk);
        while (mdc) begin n++; @(negedge clk); end
        chk(n == HALF, "R9 mdc high time", n, HALF);
        n = 0;
        while (!mdc) begin n++; @(negedge clk); end
        chk(n == HALF, "R9 mdc low time", n, HALF);

        // R3 command during frame is dropped
        wr(5'h00, cmd_val(2'd0, 2'd3, 5'h15, 5'h15, 1'b1));
        wait_idle();
        repeat (40) @(negedge clk);
        rd(5'h00, d);
        chk(d == cmd_val(2'd1, 2'd1, 5'h01, 5'h01, 1'b0), "R3 fields kept", d,
            cmd_val(2'd1, 2'd1, 5'h01, 5'h01, 1'b0));
        chk(ncap == 64, "R3 single frame", ncap, 64);

        // R10 read-only registers
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h0C, d);
        chk(d == 32'h0000_8000, "R10 read data unchanged", d, 32'h8000);
        rd(5'h10, d);
        chk(d == 0, "R10 status unchanged", d, 0);

        // random mix
        for (int i = 0; i < 14; i++) begin
            logic [1:0] st, op;
            st = 2'($urandom % 2);
            op = (st == 2'd1) ? (($urandom % 2) ? 2'd1 : 2'd2) : 2'($urandom % 4);
            do_op(st, op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), (($urandom % 8) == 0));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule